// File: doc/BRIEF.md
# DMA Transfer Control and Status Register

This block is one memory-mapped register that a host uses to run a single block transfer on a separate DMA engine. The host writes a 1 to the go bit. The register then issues a one-cycle start pulse to the engine and holds the go bit high while the transfer runs. When the engine reports that it has finished, the register clears the go bit by itself. On a clean finish it sets a done flag. On a failed finish it leaves done low and latches the cause into a small error field. Either outcome can drive a level interrupt, gated by an enable bit.

Software removes the interrupt by writing ones to the status bits it wants to clear. A new start also wipes the previous status. The engine is not part of this block. It is seen only through a done strobe and its error inputs, which are sampled in the same cycle.

Top module: `xfer_ctl_csr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register bit, so `csr_rdata` reads 0, and holds `xfer_start` and `irq` low.
- R2: A write with bit 0 set while bit 0 reads 0 sets bit 0 and raises `xfer_start` for exactly one cycle, starting with the edge that takes the write.
- R3: While bit 0 reads 1, a write carrying bit 0 set produces no further `xfer_start` pulse, and a write carrying bit 0 clear does not clear bit 0.
- R4: `eng_done` high at an edge while bit 0 reads 1 clears bit 0 at that edge, with no software write needed.
- R5: A completion with `eng_err` low sets the done flag, bit 1.
- R6: A completion with `eng_err` high leaves bit 1 at 0. It loads `eng_err_code` into bits 3:2 and sets bit 5 when `eng_err_aux` is high or when the loaded code is 0, so an error is always visible.
- R7: Bits 1, 2, 3 and 5 are write-1-to-clear, each bit on its own. Writing 0 to them has no effect. A completion in the same cycle as a clearing write takes priority.
- R8: An accepted start (see R2) clears bits 1, 2, 3 and 5.
- R9: `irq` is high exactly when bit 6 (interrupt enable) is 1 and at least one of bits 1, 2, 3 or 5 is 1. It follows the register state with no extra delay.
- R10: `eng_done` while bit 0 reads 0 changes nothing.
- R11: Bit 6 is a plain read/write bit, loaded on every write. Bit 4 and bits 7 and up always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Current register contents |
| xfer_start | output | 1 | One-cycle start request to the engine |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Completion is a failure (valid with eng_done) |
| eng_err_code | input | 2 | Failure cause code (valid with eng_done) |
| eng_err_aux | input | 1 | Additional failure flag (valid with eng_done) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach come from collisions in a single cycle. One is a completion strobe arriving in the same cycle as a write-1-to-clear of the very bits it sets. Another is a start request landing on a busy register, and a third is an error completion whose code is zero. Directed steps place each of these collisions on a chosen edge. A long run of pseudo-random writes and engine strobes then follows, with a mid-run reset. A behavioural model of the register is compared against `csr_rdata`, `xfer_start` and `irq` on every cycle.

// File: rtl/xfer_csr_pkg.sv
package xfer_csr_pkg;

  // Bit positions; software decodes these, so they are fixed.
  localparam int BIT_GO     = 0;
  localparam int BIT_DONE   = 1;
  localparam int CODE_LO    = 2;
  localparam int CODE_W     = 2;
  localparam int CODE_HI    = CODE_LO + CODE_W - 1;
  localparam int BIT_FAULT  = 5;
  localparam int BIT_IE     = 6;
  localparam int USED_TOP   = BIT_IE;

  // Write intent decoded from one bus write.
  typedef struct packed {
    logic              go_req;
    logic              clr_done;
    logic [CODE_W-1:0] clr_code;
    logic              clr_fault;
    logic              ie_load;
    logic              ie_val;
  } csr_wr_t;

  // Latched status after a completion.
  typedef struct packed {
    logic              done;
    logic [CODE_W-1:0] code;
    logic              fault;
  } csr_stat_t;

  // Interrupt level from the enable and the status.
  function automatic logic irq_level(input logic ie, input csr_stat_t st);
    return ie & (st.done | (|st.code) | st.fault);
  endfunction

  // Fault flag for an error completion: forced when the code carries no cause.
  function automatic logic fault_on_error(input logic [CODE_W-1:0] code, input logic aux);
    return aux | (code == '0);
  endfunction

  // Each clear strobe knocks out its own bit.
  function automatic csr_stat_t apply_w1c(input csr_stat_t st, input csr_wr_t w);
    csr_stat_t r;
    r.done  = st.done  & ~w.clr_done;
    r.code  = st.code  & ~w.clr_code;
    r.fault = st.fault & ~w.clr_fault;
    return r;
  endfunction

endpackage

// File: rtl/csr_write_decode.sv
module csr_write_decode
  import xfer_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output csr_wr_t           wr_cmd
);

  logic wr_unused_bits;

  always_comb begin
    wr_cmd           = '0;
    wr_cmd.go_req    = wr_en & wr_data[BIT_GO];
    wr_cmd.clr_done  = wr_en & wr_data[BIT_DONE];
    wr_cmd.clr_code  = wr_en ? wr_data[CODE_HI:CODE_LO] : '0;
    wr_cmd.clr_fault = wr_en & wr_data[BIT_FAULT];
    wr_cmd.ie_load   = wr_en;
    wr_cmd.ie_val    = wr_data[BIT_IE];
  end

  // Reserved write bits carry no meaning.
  assign wr_unused_bits = ^{wr_data[DATA_W-1:USED_TOP+1], wr_data[4]};

endmodule

// File: rtl/xfer_launch.sv
module xfer_launch (
  input  logic clk,
  input  logic rst,
  input  logic go_req,
  input  logic eng_done,
  output logic go_q,
  output logic start_q,
  output logic accept,
  output logic finish
);

  // Named events used by status capture and assertions.
  assign accept = go_req & ~go_q;
  assign finish = eng_done & go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept)      go_q <= 1'b1;
      else if (finish) go_q <= 1'b0;
    end
  end

  // R2: start request lasts a single cycle
  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R2: accepted write raises go and the pulse together
  p_accept_launches_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (go_q && start_q));

  // R3: a pulse only ever follows an idle register
  p_start_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !$past(go_q));

  // R3: only a completion can end the active state
  p_busy_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (go_q && !eng_done) |=> go_q);

  // R4: completion drops go with no software help
  p_go_self_clear_r4: assert property (@(posedge clk) disable iff (rst)
    finish |=> !go_q);

endmodule

// File: rtl/xfer_status_capture.sv
module xfer_status_capture
  import xfer_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              finish,
  input  logic              eng_err,
  input  logic [CODE_W-1:0] eng_err_code,
  input  logic              eng_err_aux,
  input  csr_wr_t           wr_cmd,
  output csr_stat_t         stat_q
);

  csr_stat_t stat_d;
  csr_stat_t stat_cleared;

  assign stat_cleared = apply_w1c(stat_q, wr_cmd);

  // Priority: new start wipes, then completion sets, then software clears.
  always_comb begin
    stat_d = stat_cleared;
    if (accept) begin
      stat_d = '0;
    end else if (finish) begin
      if (eng_err) begin
        stat_d.code  = eng_err_code;
        stat_d.fault = fault_on_error(eng_err_code, eng_err_aux);
        stat_d.done  = stat_q.done;
      end else begin
        stat_d.done  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  // R5: clean completion sets done
  p_done_on_success_r5: assert property (@(posedge clk) disable iff (rst)
    (finish && !eng_err) |=> stat_q.done);

  // R6: failed completion always leaves a visible cause
  p_error_visible_r6: assert property (@(posedge clk) disable iff (rst)
    (finish && eng_err) |=> (stat_q.fault || (stat_q.code != '0)));

  // R8: a start leaves a clean status
  p_start_wipes_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> (stat_q == '0));

  // R7: with no write and no completion the status holds
  p_status_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_cmd.ie_load && !finish) |=> $stable(stat_q));

endmodule

// File: rtl/xfer_ctl_csr.sv
module xfer_ctl_csr
  import xfer_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              xfer_start,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [1:0]        eng_err_code,
  input  logic              eng_err_aux,
  output logic              irq
);

  csr_wr_t   wr_cmd;
  csr_stat_t stat_q;
  logic      go_q;
  logic      accept;
  logic      finish;
  logic      ie_q;

  csr_write_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_cmd  (wr_cmd)
  );

  xfer_launch u_launch (
    .clk      (clk),
    .rst      (rst),
    .go_req   (wr_cmd.go_req),
    .eng_done (eng_done),
    .go_q     (go_q),
    .start_q  (xfer_start),
    .accept   (accept),
    .finish   (finish)
  );

  xfer_status_capture u_stat (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .finish       (finish),
    .eng_err      (eng_err),
    .eng_err_code (eng_err_code),
    .eng_err_aux  (eng_err_aux),
    .wr_cmd       (wr_cmd),
    .stat_q       (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                 ie_q <= 1'b0;
    else if (wr_cmd.ie_load) ie_q <= wr_cmd.ie_val;
  end

  assign irq = irq_level(ie_q, stat_q);

  always_comb begin
    csr_rdata                   = '0;
    csr_rdata[BIT_GO]           = go_q;
    csr_rdata[BIT_DONE]         = stat_q.done;
    csr_rdata[CODE_HI:CODE_LO]  = stat_q.code;
    csr_rdata[BIT_FAULT]        = stat_q.fault;
    csr_rdata[BIT_IE]           = ie_q;
  end

  // R9: an enabled completion raises the interrupt
  p_irq_on_finish_r9: assert property (@(posedge clk) disable iff (rst)
    (finish && ie_q && !wr_en) |=> irq);

  // R9: no interrupt while disabled
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    (!csr_rdata[BIT_IE]) |-> !irq);

  // R10: completion strobe while idle leaves the register alone
  p_idle_done_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !go_q && !wr_en) |=> $stable(csr_rdata));

  // R1: reset leaves everything cleared
  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (csr_rdata == '0 && !xfer_start && !irq));

endmodule

// File: tb/tb_xfer_ctl_csr.sv
module tb_xfer_ctl_csr;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] csr_rdata;
  logic          xfer_start;
  logic          eng_done;
  logic          eng_err;
  logic [1:0]    eng_err_code;
  logic          eng_err_aux;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  int m_go, m_done, m_code, m_fault, m_ie, m_start;

  always #10 clk = ~clk;

  xfer_ctl_csr #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .csr_rdata(csr_rdata), .xfer_start(xfer_start),
    .eng_done(eng_done), .eng_err(eng_err), .eng_err_code(eng_err_code),
    .eng_err_aux(eng_err_aux), .irq(irq)
  );

  task automatic model_reset();
    m_go = 0; m_done = 0; m_code = 0; m_fault = 0; m_ie = 0; m_start = 0;
  endtask

  // Behavioural next-state, from the requirement text.
  task automatic model_edge(input bit r, input bit w, input logic [DW-1:0] d,
                            input bit ed, input bit ee, input int ec, input bit ea);
    bit launch, done_now;
    if (r) begin model_reset(); return; end
    launch   = w && d[0] && (m_go == 0);
    done_now = ed && (m_go == 1);
    m_start  = launch ? 1 : 0;
    if (w) m_ie = d[6];
    if (launch) begin
      m_go = 1; m_done = 0; m_code = 0; m_fault = 0;
    end else begin
      if (w && d[1]) m_done = 0;
      if (w && d[2]) m_code = m_code & 2;
      if (w && d[3]) m_code = m_code & 1;
      if (w && d[5]) m_fault = 0;
      if (done_now) begin
        m_go = 0;
        if (ee) begin
          m_code  = ec;
          m_fault = (ea || ec == 0) ? 1 : 0;
        end else begin
          m_done = 1;
        end
      end
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [DW-1:0] d,
                      input bit ed, input bit ee, input int ec, input bit ea,
                      input string tag);
    logic [DW-1:0] exp_rd;
    bit exp_irq;
    rst = r; wr_en = w; wr_data = d; eng_done = ed; eng_err = ee;
    eng_err_code = ec[1:0]; eng_err_aux = ea;
    @(posedge clk);
    model_edge(r, w, d, ed, ee, ec, ea);
    @(negedge clk);
    exp_rd = '0;
    exp_rd[0] = m_go[0]; exp_rd[1] = m_done[0]; exp_rd[3:2] = m_code[1:0];
    exp_rd[5] = m_fault[0]; exp_rd[6] = m_ie[0];
    exp_irq = (m_ie != 0) && (m_done != 0 || m_code != 0 || m_fault != 0);
    checks++;
    if (csr_rdata !== exp_rd || xfer_start !== m_start[0] || irq !== exp_irq) begin
      fails++;
      $display("FAIL %s: rdata=%h/%h start=%b/%b irq=%b/%b (actual/expected)",
               tag, csr_rdata, exp_rd, xfer_start, m_start[0], irq, exp_irq);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [DW-1:0] d, input string tag);
    step(0, 1, d, 0, 0, 0, 0, tag);
  endtask

  task automatic fin(input bit ee, input int ec, input bit ea, input string tag);
    step(0, 0, '0, 1, ee, ec, ea, tag);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    model_reset();
    // R1: reset state
    step(1, 0, '0, 0, 0, 0, 0, "R1");
    step(1, 1, 32'hFFFF_FFFF, 1, 1, 3, 1, "R1");
    idle(2, "R1");
    // R11: enable bit read/write, reserved bits read 0
    wr(32'hFFFF_FF90, "R11");
    wr(32'h0000_0000, "R11");
    wr(32'h0000_0040, "R11");
    // R10: completion while idle ignored
    fin(0, 0, 0, "R10");
    fin(1, 2, 1, "R10");
    // R2: launch
    wr(32'h0000_0041, "R2");
    idle(2, "R2");
    // R3: busy writes ignored
    wr(32'h0000_0041, "R3");
    wr(32'h0000_0040, "R3");
    idle(1, "R3");
    // R4 and R5: clean completion, R9 interrupt
    fin(0, 0, 0, "R4");
    idle(1, "R5");
    // R7: write of zeros keeps done; W1C done
    wr(32'h0000_0040, "R7");
    wr(32'h0000_0042, "R7");
    // R6: error with code 2
    wr(32'h0000_0041, "R6");
    fin(1, 2, 0, "R6");
    // R7: clear bit 3 only, then bit 2 nothing to clear
    wr(32'h0000_0048, "R7");
    // R8: start wipes errors
    wr(32'h0000_0041, "R8");
    fin(1, 0, 0, "R6");     // code 0 forces fault
    wr(32'h0000_0041, "R8");
    fin(1, 3, 1, "R6");
    wr(32'h0000_0064, "R7"); // clear bit 2 and bit 5
    wr(32'h0000_0048, "R7");
    // R9: interrupt gated by enable
    wr(32'h0000_0041, "R9");
    fin(0, 0, 0, "R9");
    wr(32'h0000_0000, "R9");
    wr(32'h0000_0040, "R9");
    // R7: completion beats same-cycle clear
    wr(32'h0000_0041, "R7");
    step(0, 1, 32'h0000_006E, 1, 1, 1, 1, "R7");
    wr(32'h0000_0041, "R7");
    step(0, 1, 32'h0000_0042, 1, 0, 0, 0, "R7");
    // R1: reset mid-transfer
    wr(32'h0000_0041, "R1");
    step(1, 0, '0, 0, 0, 0, 0, "R1");
    idle(1, "R1");
    // Mixed pseudo-random traffic
    s = 32'h1D2C_3B4A;
    for (int i = 0; i < 3000; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      step((s[31:24] == 8'h00), (s[3:1] == 3'd0), {25'd0, s[14:8]},
           (s[18:16] == 3'd0), s[19], int'(s[21:20]), s[22], "MIX");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule